// File: doc/BRIEF.md
# Descriptor Ring Poll Scheduler

This block decides when a network controller should go and read receive or transmit descriptor entries from host memory. An interval timer runs while the controller engine is idle. It stops while a receive or transmit operation is being serviced and then continues from the value it held. The timer is cleared only by the chip reset. When the interval ends, when a packet completes, or when software strobes a transmit demand, the block checks the ownership flags and enable bits. From these it decides whether a receive poll, a transmit poll, or both are needed.

Each needed poll is recorded as pending. The pending polls are presented one at a time to a descriptor fetch port on a valid/ready handshake. A receive poll always goes ahead of a transmit poll that becomes pending in the same cycle.

The interval defaults to `2**IVL_W` idle cycles. Software can override it, but only during the window after initialization has finished and before start is asserted.

Top module: `ring_poll_sched`

## Requirements
- R1: With no override, interval expiries are spaced exactly `2**IVL_W` idle cycles apart. Each expiry re-evaluates the poll conditions.
- R2: While `eng_busy` is 1 the interval count holds its value. Once `eng_busy` returns to 0 the count resumes from that value and is never cleared, so each busy cycle lengthens the current interval by one cycle.
- R3: A write on `ivl_wr` with value V sets the interval to V+1 idle cycles. The write takes effect only when `init_done`=1 and `start`=0 in that cycle; otherwise it is ignored and the previous interval stays in force.
- R4: A trigger schedules a receive poll only if `rx_en`=1 and the controller lacks ownership of either the current receive entry or the next one. When `rx_ring_single`=1, the next entry is not considered.
- R5: While `rx_en`=0, no receive request (`req_kind`=0) is ever issued.
- R6: An interval expiry or a packet completion schedules a transmit poll only if `tx_en`=1, `poll_dis`=0 and `tx_own_cur`=0.
- R7: A one-cycle pulse on `rx_pkt_done` or `tx_pkt_done` re-evaluates both the receive and the transmit poll conditions, without waiting for the interval.
- R8: A `tx_demand` pulse immediately schedules a receive poll when R4 allows it. It also schedules a transmit poll when `tx_en`=1 and `tx_own_cur`=0, regardless of `poll_dis`. The receive request is issued before the transmit request.
- R9: Requests use `req_kind` 0 for receive and 1 for transmit. A request stays valid, with the same kind, until `req_ready` accepts it. Repeated triggers for a poll that is already pending merge into a single request.
- R10: After reset, `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive function enabled |
| tx_en | input | 1 | Transmit function enabled |
| poll_dis | input | 1 | Suppress automatic transmit polling |
| rx_own_cur | input | 1 | Controller owns the current receive entry |
| rx_own_nxt | input | 1 | Controller owns the next receive entry |
| rx_ring_single | input | 1 | Receive ring holds a single entry |
| tx_own_cur | input | 1 | Controller owns the current transmit entry |
| eng_busy | input | 1 | Receive or transmit operation in progress |
| rx_pkt_done | input | 1 | Pulse: a packet was just received |
| tx_pkt_done | input | 1 | Pulse: a packet was just transmitted |
| tx_demand | input | 1 | Pulse: software transmit demand |
| init_done | input | 1 | Initialization has finished |
| start | input | 1 | Controller started |
| ivl_wr | input | 1 | Interval override write strobe |
| ivl_wdata | input | IVL_W | Interval override value (interval = value + 1) |
| req_valid | output | 1 | Poll request pending |
| req_ready | input | 1 | Fetch port accepts the request |
| req_kind | output | 1 | Request type: 0 receive, 1 transmit |

## Verification
A table of flag combinations is walked with the timer frozen. Each row applies one trigger: a demand, a receive completion or a transmit completion. The rows separate the owned-current case from the owned-next case, and the single-entry ring from a larger ring. They also compare the effect of `poll_dis` on demand against its effect on automatic triggers, and the effect of each enable bit, so that a wrong term in either gate changes the request sequence that is seen.

With the engine left idle, the spacing between requests is measured directly. It is measured at the default interval, with busy cycles inserted, and after override writes made inside and outside the allowed window. This shows whether the count is being cleared rather than paused, and whether a write is accepted on the wrong phase.

Further directed cases cover merging of repeated demands, and a kind held steady under back-pressure while a receive poll arrives late.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;
  typedef enum logic {
    POLL_RX = 1'b0,
    POLL_TX = 1'b1
  } poll_kind_e;
endpackage

// File: rtl/poll_ivl_timer.sv
module poll_ivl_timer #(
  parameter int IVL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cfg_wr,
  input  logic             cfg_ok,
  input  logic [IVL_W-1:0] cfg_val,
  output logic             expire
);
  localparam logic [IVL_W-1:0] LIM_DEFAULT = {IVL_W{1'b1}};

  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic [IVL_W-1:0] lim_q, lim_d;
  logic             cnt_en, lim_en;

  // Count advances only while idle; never cleared except by chip reset.
  always_comb begin
    cnt_en = !busy;
    expire = cnt_en && (cnt_q == lim_q);
    cnt_d  = cnt_q;
    if (cnt_en) cnt_d = expire ? '0 : cnt_q + 1'b1;
    lim_en = cfg_wr && cfg_ok;
    lim_d  = lim_en ? cfg_val : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LIM_DEFAULT;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lim_en) lim_q <= lim_d;
    end
  end

  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_q == $past(cnt_q));
  a_r2_expire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !busy);
  a_r3_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok) |=> lim_q == $past(lim_q));
endmodule

// File: rtl/poll_req_queue.sv
module poll_req_queue
  import poll_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_rx,
  input  logic       set_tx,
  input  logic       ready,
  output logic       valid,
  output poll_kind_e kind,
  output logic       pend_rx,
  output logic       pend_tx
);
  logic       pend_rx_q, pend_rx_d;
  logic       pend_tx_q, pend_tx_d;
  logic       lock_q, lock_d;
  poll_kind_e lock_kind_q, lock_kind_d;
  logic       acc;

  always_comb begin
    valid = pend_rx_q || pend_tx_q;
    // An offered request keeps its kind; otherwise receive goes first.
    if (lock_q)         kind = lock_kind_q;
    else if (pend_rx_q) kind = POLL_RX;
    else                kind = POLL_TX;
    acc         = valid && ready;
    pend_rx_d   = set_rx || (pend_rx_q && !(acc && kind == POLL_RX));
    pend_tx_d   = set_tx || (pend_tx_q && !(acc && kind == POLL_TX));
    lock_d      = valid && !ready;
    lock_kind_d = kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rx_q   <= 1'b0;
      pend_tx_q   <= 1'b0;
      lock_q      <= 1'b0;
      lock_kind_q <= POLL_RX;
    end else begin
      pend_rx_q   <= pend_rx_d;
      pend_tx_q   <= pend_tx_d;
      lock_q      <= lock_d;
      lock_kind_q <= lock_kind_d;
    end
  end

  assign pend_rx = pend_rx_q;
  assign pend_tx = pend_tx_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(kind)));
  a_r8_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_rx_q) && $rose(pend_tx_q)) |-> kind == POLL_RX);
endmodule

// File: rtl/ring_poll_sched.sv
module ring_poll_sched
  import poll_sched_pkg::*;
#(
  parameter int IVL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             poll_dis,
  input  logic             rx_own_cur,
  input  logic             rx_own_nxt,
  input  logic             rx_ring_single,
  input  logic             tx_own_cur,
  input  logic             eng_busy,
  input  logic             rx_pkt_done,
  input  logic             tx_pkt_done,
  input  logic             tx_demand,
  input  logic             init_done,
  input  logic             start,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_wdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_kind
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic       expire, cfg_ok, pkt_done;
  logic       rx_need, tx_base, tx_auto;
  logic       set_rx, set_tx;
  logic       pend_rx, pend_tx;
  poll_kind_e kind;

  always_comb begin
    cfg_ok   = init_done && !start;
    pkt_done = rx_pkt_done || tx_pkt_done;
    rx_need  = rx_en && (!rx_own_cur || (!rx_ring_single && !rx_own_nxt));
    tx_base  = tx_en && !tx_own_cur;
    tx_auto  = tx_base && !poll_dis;
    set_rx   = (expire || pkt_done || tx_demand) && rx_need;
    set_tx   = ((expire || pkt_done) && tx_auto) || (tx_demand && tx_base);
  end

  poll_ivl_timer #(.IVL_W(IVL_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .busy    (eng_busy),
    .cfg_wr  (ivl_wr),
    .cfg_ok  (cfg_ok),
    .cfg_val (ivl_wdata),
    .expire  (expire)
  );

  poll_req_queue u_queue (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_rx  (set_rx),
    .set_tx  (set_tx),
    .ready   (req_ready),
    .valid   (req_valid),
    .kind    (kind),
    .pend_rx (pend_rx),
    .pend_tx (pend_tx)
  );

  assign req_kind = kind;

  a_r5_no_rx_when_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(pend_rx) |-> $past(rx_en));
  a_r6_tx_gate: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(pend_tx) |-> ($past(tx_en) && !$past(tx_own_cur)));
endmodule

// File: tb/ring_poll_sched_tb.sv
module ring_poll_sched_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, rx_en, tx_en, poll_dis, rx_own_cur, rx_own_nxt, rx_ring_single;
  logic tx_own_cur, eng_busy, rx_pkt_done, tx_pkt_done, tx_demand;
  logic init_done, start, ivl_wr, req_ready;
  logic [W-1:0] ivl_wdata;
  logic req_valid, req_kind;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  ring_poll_sched #(.IVL_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .poll_dis(poll_dis),
    .rx_own_cur(rx_own_cur), .rx_own_nxt(rx_own_nxt), .rx_ring_single(rx_ring_single),
    .tx_own_cur(tx_own_cur), .eng_busy(eng_busy), .rx_pkt_done(rx_pkt_done),
    .tx_pkt_done(tx_pkt_done), .tx_demand(tx_demand), .init_done(init_done),
    .start(start), .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 20000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  // Accept the currently offered request with a single ready cycle.
  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  // Count idle cycles until the next valid request.
  task automatic gap(output int g, input int busy_cyc);
    g = 0;
    if (busy_cyc > 0) begin
      eng_busy = 1'b1;
      repeat (busy_cyc) begin @(negedge clk); g++; end
      eng_busy = 1'b0;
    end
    do begin @(negedge clk); g++; end while (!req_valid && g < 200);
  endtask

  // {ev[1:0], rx_en, tx_en, poll_dis, own_cur, own_nxt, single, own_tx, exp_rx, exp_tx}
  // ev: 0 demand, 1 rx done, 2 tx done
  localparam logic [10:0] VEC [12] = '{
    {2'd0, 7'b1100000, 2'b11},  // R8 nothing owned: rx then tx
    {2'd0, 7'b1101100, 2'b01},  // R4 both rx owned: tx only
    {2'd0, 7'b1101000, 2'b11},  // R4 next not owned, ring >1
    {2'd0, 7'b1101010, 2'b01},  // R4 single ring skips next
    {2'd0, 7'b0100000, 2'b01},  // R5 rx disabled
    {2'd0, 7'b1101101, 2'b00},  // R8 all owned
    {2'd0, 7'b1000000, 2'b10},  // R8 tx disabled
    {2'd0, 7'b1111100, 2'b01},  // R8 demand ignores poll_dis
    {2'd1, 7'b1111100, 2'b00},  // R6 poll_dis blocks completion tx
    {2'd1, 7'b1100000, 2'b11},  // R7 rx done polls both
    {2'd2, 7'b1101100, 2'b01},  // R7 tx done polls tx
    {2'd2, 7'b1101001, 2'b10}   // R6 tx owned: rx only
  };

  initial begin
    int g;
    rst_n = 0; rx_en = 1; tx_en = 1; poll_dis = 0; rx_own_cur = 1; rx_own_nxt = 1;
    rx_ring_single = 0; tx_own_cur = 0; eng_busy = 1; rx_pkt_done = 0; tx_pkt_done = 0;
    tx_demand = 0; init_done = 0; start = 0; ivl_wr = 0; ivl_wdata = '0; req_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset", req_valid, 0);

    for (int i = 0; i < 12; i++) begin
      {rx_en, tx_en, poll_dis, rx_own_cur, rx_own_nxt, rx_ring_single, tx_own_cur} = VEC[i][8:2];
      @(negedge clk);
      case (VEC[i][10:9])
        2'd0: tx_demand = 1'b1;
        2'd1: rx_pkt_done = 1'b1;
        default: tx_pkt_done = 1'b1;
      endcase
      @(negedge clk);
      tx_demand = 0; rx_pkt_done = 0; tx_pkt_done = 0;
      if (VEC[i][1]) begin
        chk($sformatf("R4 vec%0d rx valid", i), req_valid, 1);
        chk($sformatf("R8 vec%0d rx kind", i), req_kind, 0);
        accept();
      end
      if (VEC[i][0]) begin
        chk($sformatf("R6 vec%0d tx valid", i), req_valid, 1);
        chk($sformatf("R9 vec%0d tx kind", i), req_kind, 1);
        accept();
      end
      chk($sformatf("R7 vec%0d drained", i), req_valid, 0);
    end

    // R9 merge: two demands become one transmit request
    rx_en = 1; tx_en = 1; poll_dis = 0; rx_own_cur = 1; rx_own_nxt = 1; tx_own_cur = 0;
    tx_demand = 1; @(negedge clk); tx_demand = 0; @(negedge clk);
    tx_demand = 1; @(negedge clk); tx_demand = 0; @(negedge clk);
    chk("R9 merged kind", req_kind, 1);
    accept();
    chk("R9 merged single", req_valid, 0);

    // R9 hold: offered tx keeps kind when rx arrives under back-pressure
    tx_demand = 1; @(negedge clk); tx_demand = 0;
    rx_own_cur = 0; rx_pkt_done = 1; @(negedge clk); rx_pkt_done = 0;
    @(negedge clk);
    chk("R9 held kind", req_kind, 1);
    accept();
    chk("R9 late rx valid", req_valid, 1);
    chk("R9 late rx kind", req_kind, 0);
    accept();
    chk("R9 drained", req_valid, 0);

    // Interval timing: only tx polls are due
    rx_own_cur = 1; rx_own_nxt = 1; req_ready = 1; eng_busy = 0;
    gap(g, 0);
    gap(g, 0); chk("R1 default interval", g, 16);
    chk("R4 periodic kind tx", req_kind, 1);
    gap(g, 5); chk("R2 paused interval", g, 21);
    gap(g, 0); chk("R2 resumes to default", g, 16);
    init_done = 1; start = 1; ivl_wdata = 4'd3; ivl_wr = 1; @(negedge clk); ivl_wr = 0;
    init_done = 0; start = 0; ivl_wr = 1; @(negedge clk); ivl_wr = 0;
    gap(g, 0);
    gap(g, 0); chk("R3 write outside window ignored", g, 16);
    init_done = 1; start = 0; ivl_wdata = 4'd5; ivl_wr = 1; @(negedge clk); ivl_wr = 0;
    start = 1;
    gap(g, 0);
    gap(g, 0); chk("R3 override interval", g, 6);
    rx_en = 0; rx_own_cur = 0;
    gap(g, 0);
    chk("R5 rx off periodic kind", req_kind, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule